// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadow Copies

This block is a 32-entry, 64-bit integer register file. It has two combinational read ports and one synchronous write port, each selected by a 5-bit register number. A second, small bank holds alternate copies of a fixed, sparse set of registers: numbers 8 through 14 and number 25. While the core runs in its privileged handler mode, accesses to those numbers reach the alternate copies. Every other register number reaches the same storage in both modes.

The mode is held in one flip-flop that steers each access to the right bank, so switching modes never moves any data. Surrounding control logic drives a mode-change request that names the mode it wants. It asks for the alternate bank when a trap is taken from outside the handler mode, and for the normal bank when an exception return targets an address with bit 0 clear. A request for the mode that is already active is refused and flagged for one cycle. Register 31 is hardwired to zero.

Top module: `bankreg_file`

## Requirements
- R1: After reset, `shadow_on` is 1, `req_err` is 0 and every register reads as zero.
- R2: Register numbers 8, 9, 10, 11, 12, 13, 14 and 25 have two copies. Reads and writes reach the alternate copy while `shadow_on` is 1 and the normal copy while it is 0. A value written in one mode is not visible in the other mode.
- R3: Register numbers 0–7, 15–24 and 26–30 have a single copy, which both modes read and write.
- R4: A request (`swap_req`=1) with `swap_to` different from `shadow_on` sets `shadow_on` to `swap_to` at the next clock edge and leaves the contents of both banks unchanged. Without a request, `shadow_on` holds its value.
- R5: A request with `swap_to` equal to `shadow_on` leaves `shadow_on` unchanged and drives `req_err` to 1 for the following cycle.
- R6: Register 31 always reads as zero on both ports, and writes to it are ignored in both modes.
- R7: A write that occurs in the same cycle as an accepted mode change goes to the bank selected by the mode from before the change.
- R8: A read that selects the same register number as a write in the same cycle returns the write data, except for register 31.
- R9: The two read ports are independent and can return different registers in the same cycle.
- R10: `req_err` is 0 in any cycle that does not follow a refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 64 | Write data |
| swap_req | input | 1 | Mode-change request strobe |
| swap_to | input | 1 | Requested mode: 1 = alternate bank, 0 = normal bank |
| shadow_on | output | 1 | Current mode: 1 = alternate bank active |
| req_err | output | 1 | Set for one cycle after a request for the mode already active |

## Verification
The bench writes different values to the same banked register number in each mode, then reads them back after several mode changes. This separates per-mode storage from a single shared copy, and shows whether the data survives a switch. It also writes unbanked numbers, including 7, 15, 24 and 26 on each side of the banked range, in one mode and reads them in the other, which exposes a boundary decoded wrongly. Writes issued in the same cycle as a mode change, a read and a write to the same number in one cycle, writes to register 31, and requests for the mode already active each check one of the corner rules in isolation.

// File: rtl/bankreg_file.sv
module bankreg_file #(
  parameter int XLEN      = 64,
  parameter int NREG      = 32,
  parameter int IDXW      = $clog2(NREG),
  parameter int SHD_LO    = 8,
  parameter int SHD_HI    = 14,
  parameter int SHD_EXTRA = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IDXW-1:0] rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            swap_req,
  input  logic            swap_to,
  output logic            shadow_on,
  output logic            req_err
);
  localparam int NSHD = SHD_HI - SHD_LO + 2;
  localparam int SW   = $clog2(NSHD);
  localparam logic [IDXW-1:0] ZERO_IDX = IDXW'(NREG - 1);

  logic [XLEN-1:0] nrm [NREG];
  logic [XLEN-1:0] shd [NSHD];

  function automatic logic is_shd(input logic [IDXW-1:0] idx);
    return (int'(idx) >= SHD_LO && int'(idx) <= SHD_HI) || int'(idx) == SHD_EXTRA;
  endfunction

  function automatic logic [SW-1:0] slot(input logic [IDXW-1:0] idx);
    if (int'(idx) == SHD_EXTRA) return SW'(NSHD - 1);
    return SW'(idx - IDXW'(SHD_LO));
  endfunction

  logic bad_req;
  logic wr_live;
  logic wr_alt;

  assign bad_req = swap_req && (swap_to == shadow_on);
  assign wr_live = wr_en && (wr_idx != ZERO_IDX);
  assign wr_alt  = shadow_on && is_shd(wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_on <= 1'b1;
      req_err   <= 1'b0;
    end else begin
      req_err <= bad_req;
      if (swap_req && !bad_req) shadow_on <= swap_to;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) nrm[i] <= '0;
      for (int j = 0; j < NSHD; j++) shd[j] <= '0;
    end else if (wr_live) begin
      if (wr_alt) shd[slot(wr_idx)] <= wr_data;
      else        nrm[wr_idx]       <= wr_data;
    end
  end

  logic [IDXW-1:0] ridx [2];
  logic [XLEN-1:0] rdat [2];
  assign ridx[0]   = rd_a_idx;
  assign ridx[1]   = rd_b_idx;
  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (ridx[p] == ZERO_IDX)                 rdat[p] = '0;
      else if (wr_live && wr_idx == ridx[p])   rdat[p] = wr_data;
      else if (shadow_on && is_shd(ridx[p]))   rdat[p] = shd[slot(ridx[p])];
      else                                     rdat[p] = nrm[ridx[p]];
    end
  end
endmodule

module bankreg_file_chk #(
  parameter int XLEN = 64,
  parameter int IDXW = 5,
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            swap_req,
  input logic            swap_to,
  input logic            shadow_on,
  input logic            req_err,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [IDXW-1:0] rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [IDXW-1:0] rd_b_idx,
  input logic [XLEN-1:0] rd_b_data
);
  localparam logic [IDXW-1:0] Z = IDXW'(NREG - 1);

  a_r4_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && swap_to != shadow_on) |=> (shadow_on == $past(swap_to)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> $stable(shadow_on));

  a_r5_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && swap_to == shadow_on) |=> (req_err && $stable(shadow_on)));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_req && swap_to == shadow_on) |=> !req_err);

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_idx == Z) |-> (rd_a_data == '0)) and ((rd_b_idx == Z) |-> (rd_b_data == '0)));

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != Z && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data));
endmodule

bind bankreg_file bankreg_file_chk #(.XLEN(XLEN), .IDXW(IDXW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .swap_to(swap_to),
  .shadow_on(shadow_on), .req_err(req_err), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
);

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = 0;
  logic        wr_en = 0, swap_req = 0, swap_to = 0;
  logic        shadow_on, req_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bankreg_file u0 (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .swap_req(swap_req), .swap_to(swap_to),
    .shadow_on(shadow_on), .req_err(req_err)
  );

  localparam logic [63:0] VA = 64'hA5A5_0000_0000_0009, VB = 64'hB0B0_0000_0000_0025,
                          VC = 64'hC3C3_0000_0000_0009, VD = 64'hD00D_0000_0000_0003,
                          VE = 64'hE00E_0000_0000_0015, VF = 64'hF00F_0000_0000_0026,
                          VH = 64'h1234_5678_9ABC_DEF0, VJ = 64'h0FED_CBA9_8765_4321,
                          VK = 64'h5555_AAAA_5555_AAAA, VG = 64'h0000_0000_0000_0007,
                          VM = 64'h0000_0000_0000_0024;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic swap(input logic to);
    @(negedge clk); swap_req = 1; swap_to = to;
    @(negedge clk); swap_req = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] idx, input logic [63:0] exp);
    rd_a_idx = idx; rd_b_idx = idx; #1;
    chk(tag, rd_a_data, exp);
    chk(tag, rd_b_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 mode after reset", 64'(shadow_on), 64'd1);
    chk("R1 err after reset", 64'(req_err), 64'd0);
    rd("R1 reg5 zero", 5'd5, 64'd0);
    rd("R1 reg9 zero", 5'd9, 64'd0);
  endtask

  task automatic t_banks;
    wr(5'd9, VA); wr(5'd25, VB);
    swap(1'b0);
    chk("R4 left alt mode", 64'(shadow_on), 64'd0);
    rd("R2 reg9 normal copy", 5'd9, 64'd0);
    rd("R2 reg25 normal copy", 5'd25, 64'd0);
    wr(5'd9, VC);
    swap(1'b1);
    rd("R2 reg9 alt copy kept", 5'd9, VA);
    rd("R2 reg25 alt copy kept", 5'd25, VB);
    swap(1'b0);
    rd("R4 reg9 normal copy kept", 5'd9, VC);
  endtask

  task automatic t_common;
    wr(5'd3, VD); wr(5'd15, VE); wr(5'd7, VG); wr(5'd24, VM);
    swap(1'b1);
    rd("R3 reg3 shared", 5'd3, VD);
    rd("R3 reg15 shared", 5'd15, VE);
    rd("R3 reg7 shared", 5'd7, VG);
    rd("R3 reg24 shared", 5'd24, VM);
    wr(5'd26, VF);
    swap(1'b0);
    rd("R3 reg26 shared", 5'd26, VF);
  endtask

  task automatic t_illegal;
    swap(1'b0);
    chk("R5 err on repeat normal", 64'(req_err), 64'd1);
    chk("R5 mode held", 64'(shadow_on), 64'd0);
    @(negedge clk);
    chk("R10 err clears", 64'(req_err), 64'd0);
    swap(1'b1);
    chk("R10 no err on legal", 64'(req_err), 64'd0);
    chk("R4 entered alt", 64'(shadow_on), 64'd1);
    swap(1'b1);
    chk("R5 err on repeat alt", 64'(req_err), 64'd1);
    chk("R5 mode held alt", 64'(shadow_on), 64'd1);
    rd("R5 contents unchanged", 5'd9, VA);
  endtask

  task automatic t_zero;
    wr(5'd31, '1);
    rd("R6 reg31 alt mode", 5'd31, 64'd0);
    swap(1'b0);
    @(negedge clk); wr_en = 1; wr_idx = 5'd31; wr_data = '1;
    rd("R6 reg31 during write", 5'd31, 64'd0);
    @(negedge clk); wr_en = 0;
    rd("R6 reg31 normal mode", 5'd31, 64'd0);
    swap(1'b1);
  endtask

  task automatic t_write_swap;
    @(negedge clk); wr_en = 1; wr_idx = 5'd10; wr_data = VH; swap_req = 1; swap_to = 0;
    @(negedge clk); wr_en = 0; swap_req = 0;
    rd("R7 reg10 normal untouched", 5'd10, 64'd0);
    @(negedge clk); wr_en = 1; wr_idx = 5'd12; wr_data = VJ; swap_req = 1; swap_to = 1;
    @(negedge clk); wr_en = 0; swap_req = 0;
    rd("R7 reg12 alt untouched", 5'd12, 64'd0);
    rd("R7 reg10 alt got write", 5'd10, VH);
    swap(1'b0);
    rd("R7 reg12 normal got write", 5'd12, VJ);
  endtask

  task automatic t_bypass;
    @(negedge clk); wr_en = 1; wr_idx = 5'd13; wr_data = VK;
    rd_a_idx = 5'd13; rd_b_idx = 5'd13; #1;
    chk("R8 bypass port A", rd_a_data, VK);
    chk("R8 bypass port B", rd_b_data, VK);
    @(negedge clk); wr_en = 0;
    rd("R8 value stored", 5'd13, VK);
  endtask

  task automatic t_dual;
    rd_a_idx = 5'd3; rd_b_idx = 5'd15; #1;
    chk("R9 port A reg3", rd_a_data, VD);
    chk("R9 port B reg15", rd_b_data, VE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_banks; t_common; t_illegal; t_zero; t_write_swap; t_bypass; t_dual;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule